// File: doc/BRIEF.md
# Configurable Programmable-Array Output Cell

This block is the logic that sits between the fixed OR plane of a sum-of-products array and one device pin. It receives the product terms wired to its output and, depending on a small set of configuration bits, turns them into a plain sum, an inverted sum, the exclusive-OR of two partial sums, or a clocked state bit held in an internal D flip-flop.

The cell also decides the pin's direction. When the direction bit selects input, the driver is released, and the value arriving at the pin is returned to the array as a new literal. The array always receives both the true and the inverted form of the fed-back literal. In registered mode that literal is the flip-flop state, so the cell can hold one state variable of a sequential design. A group of N registered cells therefore gives a machine of up to 2^N states.

High impedance is expressed through an output-enable signal, which the pad ring turns into a tri-state driver.

Top module: `pal_macrocell`

## Requirements
- R1: With `cfg_mode` = 2'b00 (sum mode), the cell value on `pin_out` is the OR of all `terms` bits.
- R2: With `cfg_mode` = 2'b01 (inverted-sum mode), the cell value on `pin_out` is the NOR of all `terms` bits.
- R3: With `cfg_mode` = 2'b10 (split mode), group A is `terms[SPLIT-1:0]` and group B is `terms[NTERMS-1:SPLIT]`. The cell value is OR(A) xor OR(B) xor `cfg_inv`, so setting `cfg_inv` = 1 gives the XNOR form.
- R4: With `cfg_mode` = 2'b11 (state mode), every rising clock edge loads the OR of all `terms` into the state flip-flop. In this mode `pin_out` shows the stored state xor `cfg_inv`.
- R5: A clock edge with `rst` = 1 clears the state flip-flop to 0, whatever the terms.
- R6: The state flip-flop keeps its value across clock edges while `cfg_mode` is not 2'b11.
- R7: `pin_oe` is 1 when `cfg_dir` = 0 (pin drives) and 0 when `cfg_dir` = 1 (pin is an input). `pin_out` still carries the cell value in both cases.
- R8: In state mode, `fb_true` equals the stored state and `fb_comp` equals its inverse, whatever `cfg_dir` and `pin_in` are.
- R9: In the three combinational modes, `fb_true` carries the pin value and `fb_comp` carries its inverse. The pin value is the cell value when `cfg_dir` = 0 and `pin_in` when `cfg_dir` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state flip-flop |
| rst | input | 1 | Synchronous reset, active high |
| terms | input | NTERMS | Product terms wired to this cell |
| cfg_mode | input | 2 | Output mode: 00 sum, 01 inverted sum, 10 split xor, 11 state |
| cfg_inv | input | 1 | Inversion for split mode and for the state output |
| cfg_dir | input | 1 | Pin direction: 0 drive, 1 input |
| pin_in | input | 1 | Value sensed at the pin |
| pin_out | output | 1 | Value to drive on the pin |
| pin_oe | output | 1 | Driver enable, 0 means high impedance |
| fb_true | output | 1 | Feedback literal, true form |
| fb_comp | output | 1 | Feedback literal, inverted form |

## Verification
The bench builds the cell with NTERMS = 4 and SPLIT = 2. With only sixteen term patterns, every term pattern can be combined with every combinational mode, every inversion and direction setting, and both pin input levels. Both split groups are exercised with both partial sums at each level. In state mode, a sequence of term patterns with changing polarity and direction covers loading, holding across a mode change, and a reset while all terms are high.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

    typedef enum logic [1:0] {
        MC_SUM     = 2'b00,
        MC_SUM_N   = 2'b01,
        MC_SPLIT_X = 2'b10,
        MC_STATE   = 2'b11
    } mc_mode_e;

    typedef struct packed {
        logic state;
    } mc_reg_t;

    localparam mc_reg_t MC_REG_RESET = '{state: 1'b0};

endpackage

// File: rtl/pal_mc_or_groups.sv
module pal_mc_or_groups #(
    parameter int NTERMS = 8,
    parameter int SPLIT  = 4
) (
    input  logic [NTERMS-1:0] terms,
    output logic              sum_all,
    output logic              sum_lo,
    output logic              sum_hi
);
    localparam int LO_W = (SPLIT > 0 && SPLIT < NTERMS) ? SPLIT : NTERMS;

    assign sum_all = |terms;

    generate
        if (SPLIT > 0 && SPLIT < NTERMS) begin : g_split
            localparam int HI_W = NTERMS - LO_W;
            logic [LO_W-1:0] lo_terms;
            logic [HI_W-1:0] hi_terms;
            assign lo_terms = terms[LO_W-1:0];
            assign hi_terms = terms[NTERMS-1:LO_W];
            assign sum_lo   = |lo_terms;
            assign sum_hi   = |hi_terms;
        end else begin : g_nosplit
            // Degenerate split: whole set in group A, group B empty.
            assign sum_lo = |terms;
            assign sum_hi = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pal_mc_out_sel.sv
module pal_mc_out_sel
    import pal_mc_pkg::*;
(
    input  mc_mode_e mode,
    input  logic     inv,
    input  logic     sum_all,
    input  logic     sum_lo,
    input  logic     sum_hi,
    input  logic     state_q,
    output logic     cell_val,
    output logic     is_state
);
    always_comb begin
        is_state = 1'b0;
        unique case (mode)
            MC_SUM:     cell_val = sum_all;
            MC_SUM_N:   cell_val = ~sum_all;
            MC_SPLIT_X: cell_val = sum_lo ^ sum_hi ^ inv;
            MC_STATE: begin
                cell_val = state_q ^ inv;
                is_state = 1'b1;
            end
            default:    cell_val = sum_all;
        endcase
    end
endmodule

// File: rtl/pal_mc_pin_io.sv
module pal_mc_pin_io (
    input  logic dir_in,
    input  logic is_state,
    input  logic cell_val,
    input  logic state_q,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_true,
    output logic fb_comp
);
    logic pin_val;

    assign pin_oe  = ~dir_in;
    assign pin_out = cell_val;
    assign pin_val = dir_in ? pin_in : cell_val;
    assign fb_true = is_state ? state_q : pin_val;
    assign fb_comp = ~fb_true;
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_mc_pkg::*;
#(
    parameter int NTERMS = 8,
    parameter int SPLIT  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NTERMS-1:0] terms,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_inv,
    input  logic              cfg_dir,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_true,
    output logic              fb_comp
);
    mc_mode_e mode;
    logic     sum_all, sum_lo, sum_hi;
    logic     cell_val, is_state;
    mc_reg_t  r_d, r_q;

    assign mode = mc_mode_e'(cfg_mode);

    pal_mc_or_groups #(.NTERMS(NTERMS), .SPLIT(SPLIT)) u_or (
        .terms   (terms),
        .sum_all (sum_all),
        .sum_lo  (sum_lo),
        .sum_hi  (sum_hi)
    );

    pal_mc_out_sel u_sel (
        .mode     (mode),
        .inv      (cfg_inv),
        .sum_all  (sum_all),
        .sum_lo   (sum_lo),
        .sum_hi   (sum_hi),
        .state_q  (r_q.state),
        .cell_val (cell_val),
        .is_state (is_state)
    );

    pal_mc_pin_io u_pin (
        .dir_in   (cfg_dir),
        .is_state (is_state),
        .cell_val (cell_val),
        .state_q  (r_q.state),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb_true  (fb_true),
        .fb_comp  (fb_comp)
    );

    always_comb begin
        r_d = r_q;
        if (is_state) begin
            r_d.state = sum_all;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= MC_REG_RESET;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/pal_mc_checker.sv
module pal_mc_checker #(
    parameter int NTERMS = 8,
    parameter int SPLIT  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NTERMS-1:0] terms,
    input logic [1:0]        cfg_mode,
    input logic              cfg_inv,
    input logic              cfg_dir,
    input logic              pin_in,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              fb_true,
    input logic              fb_comp
);
    a_r1_sum_mode: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00) |-> (pin_out == (|terms)));

    a_r2_nor_mode: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b01) |-> (pin_out == !(|terms)));

    a_r4_state_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b11) |=> ((cfg_mode != 2'b11) || (fb_true == $past(|terms))));

    a_r5_reset_clear: assert property (@(posedge clk)
        rst |=> ((cfg_mode != 2'b11) || (fb_true == 1'b0)));

    a_r6_state_hold: assert property (@(posedge clk) disable iff (rst)
        ((cfg_mode == 2'b11) && (cfg_mode != 2'b11 ? 1'b0 : 1'b1)) |=>
        ((cfg_mode != 2'b11) || (pin_out == (fb_true ^ cfg_inv))));

    a_r7_oe_dir: assert property (@(posedge clk) disable iff (rst)
        pin_oe != cfg_dir);

    a_r8_r9_comp_pair: assert property (@(posedge clk) disable iff (rst)
        fb_comp != fb_true);

    a_r9_input_fb: assert property (@(posedge clk) disable iff (rst)
        ((cfg_mode != 2'b11) && cfg_dir) |-> (fb_true == pin_in));

    a_r9_drive_fb: assert property (@(posedge clk) disable iff (rst)
        ((cfg_mode != 2'b11) && !cfg_dir) |-> (fb_true == pin_out));
endmodule

bind pal_macrocell pal_mc_checker #(.NTERMS(NTERMS), .SPLIT(SPLIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .terms    (terms),
    .cfg_mode (cfg_mode),
    .cfg_inv  (cfg_inv),
    .cfg_dir  (cfg_dir),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_true  (fb_true),
    .fb_comp  (fb_comp)
);

// File: tb/sim_pal_macrocell.sv
module sim_pal_macrocell;
    localparam int NT = 4;
    localparam int SP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] terms = '0;
    logic [1:0]    cfg_mode = 2'b11;
    logic          cfg_inv = 1'b0;
    logic          cfg_dir = 1'b0;
    logic          pin_in = 1'b0;
    logic          pin_out, pin_oe, fb_true, fb_comp;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic exp_q;

    always #4 clk = ~clk;

    pal_macrocell #(.NTERMS(NT), .SPLIT(SP)) u0 (
        .clk(clk), .rst(rst), .terms(terms), .cfg_mode(cfg_mode),
        .cfg_inv(cfg_inv), .cfg_dir(cfg_dir), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b (mode=%b inv=%b dir=%b terms=%b pin_in=%b)",
                     req, act, exp, cfg_mode, cfg_inv, cfg_dir, terms, pin_in);
        end
    endtask

    task automatic check_state_outputs();
        chk("R8 fb_true", fb_true, exp_q);
        chk("R8 fb_comp", fb_comp, ~exp_q);
        chk("R4 pin_out", pin_out, exp_q ^ cfg_inv);
        chk("R7 pin_oe", pin_oe, ~cfg_dir);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset state (R5)
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q = 1'b0;
        #1;
        chk("R5 reset fb_true", fb_true, 1'b0);
        chk("R5 reset pin_out", pin_out, 1'b0);
        chk("R7 reset pin_oe", pin_oe, 1'b1);

        // Combinational sweep: R1 R2 R3 R7 R9
        for (int m = 0; m < 3; m++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int t = 0; t < 16; t++) begin
                        for (int p = 0; p < 2; p++) begin
                            logic sa, lo, hi, cv, pv;
                            @(negedge clk);
                            cfg_mode = 2'(m);
                            cfg_inv  = 1'(iv);
                            cfg_dir  = 1'(d);
                            terms    = 4'(t);
                            pin_in   = 1'(p);
                            sa = (t != 0);
                            lo = ((t & 3) != 0);
                            hi = ((t & 12) != 0);
                            if (m == 0) cv = sa;
                            else if (m == 1) cv = ~sa;
                            else cv = lo ^ hi ^ 1'(iv);
                            pv = (d == 1) ? 1'(p) : cv;
                            #1;
                            if (m == 0) chk("R1 sum", pin_out, cv);
                            else if (m == 1) chk("R2 nor", pin_out, cv);
                            else chk("R3 split xor", pin_out, cv);
                            chk("R7 oe", pin_oe, 1'(d == 0));
                            chk("R9 fb_true", fb_true, pv);
                            chk("R9 fb_comp", fb_comp, ~pv);
                        end
                    end
                end
            end
        end

        // Register untouched by the sweep (R6): still 0 from reset
        @(negedge clk);
        cfg_mode = 2'b11; cfg_inv = 1'b0; cfg_dir = 1'b0;
        #1;
        chk("R6 hold after sweep", fb_true, 1'b0);

        // State mode loading sequence: R4 R8
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            cfg_mode = 2'b11;
            terms    = 4'((k * 7 + 3) % 16 & ((k % 3 == 0) ? 0 : 15));
            cfg_inv  = 1'(k % 2);
            cfg_dir  = 1'((k / 2) % 2);
            pin_in   = 1'((k / 4) % 2);
            @(posedge clk);
            exp_q = (terms != 0);
            #1;
            check_state_outputs();
        end

        // Load a 1, then hold across other modes (R6)
        @(negedge clk);
        cfg_mode = 2'b11; terms = 4'b0100; cfg_inv = 1'b0; cfg_dir = 1'b0;
        @(posedge clk);
        exp_q = 1'b1;
        #1;
        check_state_outputs();
        @(negedge clk);
        cfg_mode = 2'b00; terms = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cfg_mode = 2'b10; terms = 4'b0000;
        @(posedge clk);
        @(negedge clk);
        cfg_mode = 2'b11; cfg_inv = 1'b1; cfg_dir = 1'b1; pin_in = 1'b0;
        #1;
        chk("R6 held state", fb_true, 1'b1);
        chk("R8 comp held", fb_comp, 1'b0);
        chk("R4 inverted pin", pin_out, 1'b0);

        // Reset with all terms high (R5)
        @(negedge clk);
        rst = 1'b1; terms = 4'b1111; cfg_inv = 1'b0;
        @(posedge clk);
        exp_q = 1'b0;
        #1;
        chk("R5 reset over terms", fb_true, 1'b0);
        chk("R5 reset pin", pin_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        exp_q = 1'b1;
        #1;
        check_state_outputs();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule